// File: doc/BRIEF.md
# Transmit Character Front End

This block sits at the parallel input of a serial link transmitter. On every rising edge of the word clock it decides which character goes out in the next byte period and presents it as a character descriptor: a data byte, a special-character flag, a violation flag, a bypass flag and a raw 10-bit word. A downstream 8b/10b encoder or a serializer consumes the descriptor. The code tables are not part of this block.

Two active-low load enables make the block fit both FIFO styles. The immediate enable captures the inputs on the edge where it is seen low. The deferred enable captures the inputs present on the edge after it is seen low. This suits FIFOs whose data appears one clock after the read strobe. Any byte period in which nothing is captured is filled with the K28.5 comma, so the link keeps its alignment. A bypass input marks the character as raw, so that the ten input bits go straight to the serializer. A test input turns the block into a 9-bit pattern generator. The generator repeats every 511 characters and produces data characters, special characters and violation requests.

Top module: `tx_char_front`

## Requirements
- R1: While reset is held, the descriptor is the comma fill: q_byte=8'hBC, q_k=1, q_viol=0, q_bypass=0, q_raw=10'h2F2. The internal deferred-load request is cleared, and the pattern register returns to SEED.
- R2: With test_mode low, ld_now_n low at a rising edge captures din, kflag and viol_req on that edge. The captured values appear on q_byte, q_k and q_viol after that edge, which is a latency of one cycle.
- R3: With test_mode low, ld_next_n low (and ld_now_n high) at an edge makes the following edge capture the inputs present at that edge, whatever the enables are then. Holding ld_next_n low keeps the captures going on every edge.
- R4: An edge with test_mode low and no capture produces the fill descriptor: q_byte=8'hBC, q_k=1, q_viol=0. q_raw is 10'h2F2 when raw_mode is low and 10'h0FA (the K28.5 code, bits listed from the first bit sent to the last) when raw_mode is high.
- R5: A captured character carries kflag to q_k (1 = special code, 0 = data) and viol_req to q_viol (1 = send the violation symbol). It also sets q_raw={din,kflag,viol_req}, with din in bits 9:2, kflag in bit 1 and viol_req in bit 0.
- R6: When both enables are low at one edge, the immediate capture is made and no deferred capture follows. If both enables are then high at the next edge, that edge produces the fill.
- R7: With test_mode low, q_bypass follows raw_mode as sampled at the edge. A captured raw character gives q_raw={din,kflag,viol_req}.
- R8: With test_mode high, each edge ignores the enables and raw_mode. It outputs the pattern state s: q_byte=s[7:0], q_k=s[8], q_viol=(s[8:7]==2'b11 && s[1:0]==2'b11), q_bypass=0, q_raw={q_byte,q_k,q_viol}. It then advances s to {s[7:0], s[8]^s[4]}. While test_mode is low, s is held at SEED and any deferred request is dropped.
- R9: The test pattern repeats every 511 characters, and one period contains data characters, special characters and violation requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock, rising edge |
| rst_n | input | 1 | Active-low reset, synchronous |
| ld_now_n | input | 1 | Active-low enable that captures on this edge |
| ld_next_n | input | 1 | Active-low enable that captures on the following edge |
| din | input | 8 | Character byte |
| kflag | input | 1 | 1 = special code, 0 = data |
| viol_req | input | 1 | Request to send the violation symbol |
| raw_mode | input | 1 | Bypass coding and send ten raw bits |
| test_mode | input | 1 | Run the 511-character test pattern |
| q_byte | output | 8 | Descriptor byte |
| q_k | output | 1 | Descriptor special flag |
| q_viol | output | 1 | Descriptor violation flag |
| q_bypass | output | 1 | Descriptor raw flag |
| q_raw | output | 10 | Raw 10-bit word |

## Verification
The bench overrides SEED with 9'h0A5 instead of the default 9'h001, so the pattern checks show that the seed parameter reaches the outputs and is not a hard-wired constant. With this seed, a run of more than 511 test characters covers a full period and its wrap-around. It also covers the re-seed that happens when the test input drops and is raised again. The bench checks the loading behaviour with both enable styles, with enables held low back to back, and with both enables low on the same edge.

// File: rtl/tx_char_front.sv
module tx_char_front #(
  parameter logic [8:0] SEED = 9'h001
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ld_now_n,
  input  logic       ld_next_n,
  input  logic [7:0] din,
  input  logic       kflag,
  input  logic       viol_req,
  input  logic       raw_mode,
  input  logic       test_mode,
  output logic [7:0] q_byte,
  output logic       q_k,
  output logic       q_viol,
  output logic       q_bypass,
  output logic [9:0] q_raw
);
  localparam logic [7:0] SYNC_BYTE = 8'hBC;
  localparam logic [9:0] SYNC_CODE = 10'h0FA;
  localparam logic [9:0] SYNC_DESC = {SYNC_BYTE, 2'b10};

  logic       pend;
  logic [8:0] lfsr;
  logic       take;
  logic       lf_fb;
  logic       lf_viol;

  assign take    = !ld_now_n || pend;
  assign lf_fb   = lfsr[8] ^ lfsr[4];
  assign lf_viol = (lfsr[8:7] == 2'b11) && (lfsr[1:0] == 2'b11);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend     <= 1'b0;
      lfsr     <= SEED;
      q_byte   <= SYNC_BYTE;
      q_k      <= 1'b1;
      q_viol   <= 1'b0;
      q_bypass <= 1'b0;
      q_raw    <= SYNC_DESC;
    end else if (test_mode) begin
      pend     <= 1'b0;
      lfsr     <= {lfsr[7:0], lf_fb};
      q_byte   <= lfsr[7:0];
      q_k      <= lfsr[8];
      q_viol   <= lf_viol;
      q_bypass <= 1'b0;
      q_raw    <= {lfsr[7:0], lfsr[8], lf_viol};
    end else begin
      pend     <= ld_now_n && !ld_next_n;
      lfsr     <= SEED;
      q_bypass <= raw_mode;
      if (take) begin
        q_byte <= din;
        q_k    <= kflag;
        q_viol <= viol_req;
        q_raw  <= {din, kflag, viol_req};
      end else begin
        q_byte <= SYNC_BYTE;
        q_k    <= 1'b1;
        q_viol <= 1'b0;
        q_raw  <= raw_mode ? SYNC_CODE : SYNC_DESC;
      end
    end
  end
endmodule

module tx_char_front_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ld_now_n,
  input logic       ld_next_n,
  input logic [7:0] din,
  input logic       kflag,
  input logic       viol_req,
  input logic       raw_mode,
  input logic       test_mode,
  input logic       pend,
  input logic [7:0] q_byte,
  input logic       q_k,
  input logic       q_viol,
  input logic       q_bypass,
  input logic [9:0] q_raw
);
  AST_NOW_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (!test_mode && !ld_now_n) |=> (q_byte == $past(din) && q_k == $past(kflag) && q_viol == $past(viol_req))); // R2
  AST_NEXT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (!test_mode && ld_now_n && !ld_next_n) ##1 !test_mode |=> (q_byte == $past(din) && q_raw == $past({din, kflag, viol_req}))); // R3
  AST_FILL_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
    (!test_mode && ld_now_n && !pend) |=> (q_byte == 8'hBC && q_k && !q_viol)); // R4
  AST_BOTH_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!test_mode && !ld_now_n && !ld_next_n) ##1 (!test_mode && ld_now_n && ld_next_n) |=> (q_byte == 8'hBC && q_k)); // R6
  AST_RAW_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (!test_mode && !ld_now_n && raw_mode) |=> (q_bypass && q_raw == $past({din, kflag, viol_req}))); // R7
  AST_TEST_COOKED: assert property (@(posedge clk) disable iff (!rst_n)
    test_mode |=> (!q_bypass && q_raw == {q_byte, q_k, q_viol} && !pend)); // R8
endmodule

bind tx_char_front tx_char_front_chk u_chk (.*);

// File: tb/sim_tx_char_front.sv
module sim_tx_char_front;
  localparam logic [8:0] SEED = 9'h0A5;

  typedef struct packed {
    logic [7:0] b;
    logic       k;
    logic       v;
    logic       y;
    logic [9:0] r;
  } desc_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ld_now_n = 1'b1, ld_next_n = 1'b1;
  logic [7:0] din = 8'h00;
  logic kflag = 1'b0, viol_req = 1'b0, raw_mode = 1'b0, test_mode = 1'b0;
  logic [7:0] q_byte;
  logic q_k, q_viol, q_bypass;
  logic [9:0] q_raw;

  int total = 0, bad = 0, ncyc = 0;
  int seen_k = 0, seen_v = 0, seen_d = 0;
  desc_t exp_q[$];
  string tag_q[$];
  int    cyc_q[$];
  logic       m_pend = 1'b0;
  logic [8:0] m_lf = SEED;

  tx_char_front #(.SEED(SEED)) u0 (
    .clk(clk), .rst_n(rst_n), .ld_now_n(ld_now_n), .ld_next_n(ld_next_n),
    .din(din), .kflag(kflag), .viol_req(viol_req), .raw_mode(raw_mode),
    .test_mode(test_mode), .q_byte(q_byte), .q_k(q_k), .q_viol(q_viol),
    .q_bypass(q_bypass), .q_raw(q_raw)
  );

  always #5 clk = ~clk;
  always @(posedge clk) ncyc <= ncyc + 1;

  function automatic desc_t got();
    got = '{b: q_byte, k: q_k, v: q_viol, y: q_bypass, r: q_raw};
  endfunction

  task automatic check(input string tag, input desc_t e);
    desc_t a;
    a = got();
    total++;
    if (a !== e) begin
      bad++;
      $display("FAIL %s: got %h expected %h", tag, a, e);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && exp_q.size() > 0 && cyc_q[0] < ncyc) begin
      desc_t e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      void'(cyc_q.pop_front());
      check(t, e);
      if (t == "R8 pattern") begin
        if (q_viol) seen_v++;
        else if (q_k) seen_k++;
        else seen_d++;
      end
    end
  end

  task automatic cyc(input logic now_n, input logic next_n, input logic [7:0] d,
                     input logic k, input logic v, input logic raw, input logic tst,
                     input string tag);
    desc_t e;
    ld_now_n = now_n; ld_next_n = next_n; din = d; kflag = k;
    viol_req = v; raw_mode = raw; test_mode = tst;
    if (tst) begin
      e.b = m_lf[7:0]; e.k = m_lf[8];
      e.v = (m_lf[8:7] == 2'b11) && (m_lf[1:0] == 2'b11);
      e.y = 1'b0; e.r = {e.b, e.k, e.v};
      m_pend = 1'b0;
      m_lf = {m_lf[7:0], m_lf[8] ^ m_lf[4]};
    end else begin
      if (!now_n || m_pend) e = '{b: d, k: k, v: v, y: raw, r: {d, k, v}};
      else e = '{b: 8'hBC, k: 1'b1, v: 1'b0, y: raw, r: raw ? 10'h0FA : 10'h2F2};
      m_pend = now_n && !next_n;
      m_lf = SEED;
    end
    exp_q.push_back(e); tag_q.push_back(tag); cyc_q.push_back(ncyc);
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 10);
    bad++; total++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset", '{b: 8'hBC, k: 1'b1, v: 1'b0, y: 1'b0, r: 10'h2F2});
    rst_n = 1'b1;
    cyc(1, 1, 8'h5A, 0, 0, 0, 0, "R4 idle fill");
    cyc(1, 1, 8'h77, 1, 1, 0, 0, "R4 idle fill");
    cyc(0, 1, 8'hA5, 0, 0, 0, 0, "R2 data load");
    cyc(0, 1, 8'h1C, 1, 0, 0, 0, "R5 special load");
    cyc(0, 1, 8'h00, 0, 1, 0, 0, "R5 violation load");
    cyc(0, 1, 8'hFF, 1, 1, 0, 0, "R2 back to back");
    cyc(1, 0, 8'h99, 0, 0, 0, 0, "R3 arm");
    cyc(1, 1, 8'h3C, 1, 0, 0, 0, "R3 deferred load");
    cyc(1, 1, 8'h44, 0, 0, 0, 0, "R4 after deferred");
    cyc(1, 0, 8'h01, 0, 0, 0, 0, "R3 chain arm");
    cyc(1, 0, 8'h02, 0, 1, 0, 0, "R3 chain one");
    cyc(1, 1, 8'h03, 1, 0, 0, 0, "R3 chain two");
    cyc(1, 1, 8'h04, 0, 0, 0, 0, "R3 chain end");
    cyc(1, 0, 8'h10, 0, 0, 0, 0, "R6 arm");
    cyc(0, 0, 8'h11, 0, 0, 0, 0, "R6 both low");
    cyc(1, 1, 8'h22, 0, 0, 0, 0, "R6 cancelled");
    cyc(1, 0, 8'h30, 0, 0, 0, 0, "R3 arm then now");
    cyc(0, 1, 8'h31, 1, 0, 0, 0, "R3 with now");
    cyc(1, 1, 8'h32, 0, 0, 0, 0, "R3 no repeat");
    cyc(0, 1, 8'hC3, 1, 0, 1, 0, "R7 raw load");
    cyc(1, 1, 8'h55, 0, 1, 1, 0, "R7 raw fill");
    cyc(1, 0, 8'h66, 0, 0, 1, 0, "R7 raw arm");
    cyc(1, 1, 8'h67, 0, 1, 1, 0, "R7 raw deferred");
    cyc(1, 0, 8'h80, 0, 0, 0, 0, "R8 arm before test");
    for (int i = 0; i < 600; i++)
      cyc(i[0], 0, 8'(i), i[1], i[2], i[3], 1, "R8 pattern");
    cyc(1, 1, 8'h12, 0, 0, 0, 0, "R8 exit no pending");
    for (int i = 0; i < 4; i++)
      cyc(0, 0, 8'hEE, 1, 1, 1, 1, "R8 reseed");
    for (int i = 0; i < 40; i++) begin
      int unsigned r;
      r = $urandom;
      cyc(r[0], r[1], r[15:8], r[2], r[3], r[4], 0, "mix R2 R3 R4");
    end
    cyc(1, 1, 8'h00, 0, 0, 0, 0, "R4 final fill");
    @(negedge clk);
    total++;
    if (seen_k == 0 || seen_v == 0 || seen_d == 0) begin
      bad++;
      $display("FAIL R9 coverage: got k=%0d v=%0d d=%0d expected all nonzero", seen_k, seen_v, seen_d);
    end
    total++;
    if (exp_q.size() != 0) begin
      bad++;
      $display("FAIL scoreboard drain: got %0d expected 0", exp_q.size());
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule